// File: doc/BRIEF.md
# Ten-to-eight line symbol decoder with disparity tracking

The block turns one aligned 10-bit line symbol per qualified clock into the 8-bit byte it carries. Three status flags come with the byte: a control-symbol flag, an auxiliary flag and an error flag. The running disparity is held from word to word, so the block reports two kinds of fault. One is a code word that is not legal under either disparity. The other is a code word that is legal only under the disparity the line is not currently at. The byte and all three flags come out of one register stage, so they always describe the same word.

The auxiliary flag means different things depending on the error flag. With the error flag low, the auxiliary flag marks the comma symbol K28.5. With the error flag high, it tells the two kinds of fault apart. A fixed ranking applies when one word meets more than one condition: illegal code first, then wrong disparity, then comma. The block sits behind a word aligner. It drives nothing while its valid strobe is low.

The disparity tracker is a two-state machine with the states DISP_NEG and DISP_POS. It enters DISP_NEG at reset. On each qualified word it takes one of three transitions:
- SWING_UP: DISP_NEG to DISP_POS, when the word leaves the line positive.
- SWING_DOWN: DISP_POS to DISP_NEG, when the word leaves the line negative.
- HOLD: the state stays as it is, when the word leaves the line balanced.

The output stage resolves each word to one of four verdicts: V_DATA, V_COMMA, V_BADCODE or V_BADDISP.

Top module: `lane_decoder`

## Requirements
- R1: `sym_in[9:4]` carries the six-bit sub-block abcdei, with a in bit 9. `sym_in[3:0]` carries the four-bit sub-block fghj, with f in bit 3. A data symbol that is legal at the current disparity and is presented with `sym_vld` high appears one clock later on `byte_out`. The layout of `byte_out` is {HGF, EDCBA}, with A in bit 0. On such a word `ctl_out`, `aux_out` and `err_out` are all low.
- R2: The twelve control symbols set `ctl_out` high and put their byte value on `byte_out`, when legal at the current disparity. The twelve are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7.
- R3: `aux_out` is high with `err_out` low only for a legal K28.5. In that case `ctl_out` is high and `byte_out` is 8'hBC.
- R4: A code word that is legal under neither disparity gives `err_out`=1 and `aux_out`=1, with `ctl_out`=0 and `byte_out`=0.
- R5: A code word that is legal only under the opposite disparity gives `err_out`=1 and `aux_out`=0, with `ctl_out`=0 and `byte_out`=0.
- R6: When one word meets several conditions, only the highest-ranked one is reported. The ranking is illegal code, then wrong disparity, then comma. So a K28.5 at the wrong disparity reports a disparity fault, and a word that is wrong in both ways reports an illegal code.
- R7: The running disparity resets to negative. On every qualified word, errors included, it is updated in this order:
  - the four-bit sub-block sets it positive if it has more than two ones and negative if it has fewer than two;
  - otherwise the six-bit sub-block sets it positive if it has more than three ones and negative if it has fewer than three;
  - otherwise it is left unchanged.
- R8: While `sym_vld` is low, all outputs hold their values and the running disparity does not change, whatever `sym_in` carries.
- R9: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_vld | input | 1 | Qualifies `sym_in` for this clock |
| sym_in | input | 10 | Aligned line symbol, abcdei in bits 9..4, fghj in bits 3..0 |
| byte_out | output | 8 | Recovered byte {HGF, EDCBA}, zero on an error |
| ctl_out | output | 1 | Control symbol received |
| aux_out | output | 1 | Comma when `err_out` is low; illegal-code fault when `err_out` is high |
| err_out | output | 1 | Fault on the word |

## Verification
The disparity state cannot be read directly. It shows up as fault reports. A tracker left in the wrong state makes the next legal word that has unbalanced sub-blocks come out as a disparity fault on the following clock. A tracker stuck in one state fails on the first pair of words that should drive it both ways. Every one of the 1024 code words is therefore applied under both disparities, with a legal steering word inserted wherever the bench's own disparity model must flip. A wrong legality rule then appears one clock after the offending word, as a wrong verdict pair on `err_out` and `aux_out`.

// File: rtl/lane_decoder_pkg.sv
`timescale 1ns/1ps
package lane_decoder_pkg;

    localparam int SYM_W  = 10;
    localparam int HI_W   = 6;
    localparam int LO_W   = 4;
    localparam int BYTE_W = 8;
    localparam int X_W    = 5;
    localparam int Y_W    = BYTE_W - X_W;
    localparam int CNT_W  = 3;

    typedef enum logic {
        DISP_NEG = 1'b0,
        DISP_POS = 1'b1
    } disp_e;

    typedef enum logic [1:0] {
        V_DATA    = 2'd0,
        V_COMMA   = 2'd1,
        V_BADCODE = 2'd2,
        V_BADDISP = 2'd3
    } verdict_e;

    // Six-bit sub-block classification
    typedef struct packed {
        logic           valid;
        logic [X_W-1:0] x;
        logic           need_neg;
        logic           need_pos;
        logic           go_pos;
        logic           go_neg;
        logic           is_k28;
        logic           k28_pos;
        logic           run_hi;   // x = 17, 18, 20
        logic           run_lo;   // x = 11, 13, 14
        logic           kx7;      // x = 23, 27, 29, 30
    } hi_info_t;

    // Four-bit sub-block classification
    typedef struct packed {
        logic           valid;
        logic [Y_W-1:0] y;
        logic           need_neg;
        logic           need_pos;
        logic           go_pos;
        logic           go_neg;
        logic           alt7;
        logic           pri7;
        logic           mid_bal;
    } lo_info_t;

endpackage

// File: rtl/lane_dec_hi.sv
`timescale 1ns/1ps
module lane_dec_hi
    import lane_decoder_pkg::*;
(
    input  logic [HI_W-1:0] sub_i,
    output hi_info_t        info_o
);

    logic [CNT_W-1:0] ones;

    assign ones = CNT_W'($countones(sub_i));

    always_comb begin
        info_o          = '0;
        info_o.valid    = 1'b1;
        info_o.go_pos   = (ones > CNT_W'(3));
        info_o.go_neg   = (ones < CNT_W'(3));
        info_o.need_neg = info_o.go_pos || (sub_i == 6'b111000);
        info_o.need_pos = info_o.go_neg || (sub_i == 6'b000111);
        unique case (sub_i)
            6'b100111, 6'b011000: info_o.x = 5'd0;
            6'b011101, 6'b100010: info_o.x = 5'd1;
            6'b101101, 6'b010010: info_o.x = 5'd2;
            6'b110001:            info_o.x = 5'd3;
            6'b110101, 6'b001010: info_o.x = 5'd4;
            6'b101001:            info_o.x = 5'd5;
            6'b011001:            info_o.x = 5'd6;
            6'b111000, 6'b000111: info_o.x = 5'd7;
            6'b111001, 6'b000110: info_o.x = 5'd8;
            6'b100101:            info_o.x = 5'd9;
            6'b010101:            info_o.x = 5'd10;
            6'b110100: begin info_o.x = 5'd11; info_o.run_lo = 1'b1; end
            6'b001101:            info_o.x = 5'd12;
            6'b101100: begin info_o.x = 5'd13; info_o.run_lo = 1'b1; end
            6'b011100: begin info_o.x = 5'd14; info_o.run_lo = 1'b1; end
            6'b010111, 6'b101000: info_o.x = 5'd15;
            6'b011011, 6'b100100: info_o.x = 5'd16;
            6'b100011: begin info_o.x = 5'd17; info_o.run_hi = 1'b1; end
            6'b010011: begin info_o.x = 5'd18; info_o.run_hi = 1'b1; end
            6'b110010:            info_o.x = 5'd19;
            6'b001011: begin info_o.x = 5'd20; info_o.run_hi = 1'b1; end
            6'b101010:            info_o.x = 5'd21;
            6'b011010:            info_o.x = 5'd22;
            6'b111010, 6'b000101: begin info_o.x = 5'd23; info_o.kx7 = 1'b1; end
            6'b110011, 6'b001100: info_o.x = 5'd24;
            6'b100110:            info_o.x = 5'd25;
            6'b010110:            info_o.x = 5'd26;
            6'b110110, 6'b001001: begin info_o.x = 5'd27; info_o.kx7 = 1'b1; end
            6'b001110:            info_o.x = 5'd28;
            6'b101110, 6'b010001: begin info_o.x = 5'd29; info_o.kx7 = 1'b1; end
            6'b011110, 6'b100001: begin info_o.x = 5'd30; info_o.kx7 = 1'b1; end
            6'b101011, 6'b010100: info_o.x = 5'd31;
            6'b001111: begin info_o.x = 5'd28; info_o.is_k28 = 1'b1; end
            6'b110000: begin
                info_o.x       = 5'd28;
                info_o.is_k28  = 1'b1;
                info_o.k28_pos = 1'b1;
            end
            default:              info_o.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_dec_lo.sv
`timescale 1ns/1ps
module lane_dec_lo
    import lane_decoder_pkg::*;
(
    input  logic [LO_W-1:0] sub_i,
    output lo_info_t        info_o
);

    logic [CNT_W-1:0] ones;

    assign ones = CNT_W'($countones(sub_i));

    always_comb begin
        info_o          = '0;
        info_o.valid    = 1'b1;
        info_o.go_pos   = (ones > CNT_W'(2));
        info_o.go_neg   = (ones < CNT_W'(2));
        info_o.need_neg = info_o.go_pos || (sub_i == 4'b1100);
        info_o.need_pos = info_o.go_neg || (sub_i == 4'b0011);
        unique case (sub_i)
            4'b1011, 4'b0100: info_o.y = 3'd0;
            4'b1001: begin info_o.y = 3'd1; info_o.mid_bal = 1'b1; end
            4'b0101: begin info_o.y = 3'd2; info_o.mid_bal = 1'b1; end
            4'b1100, 4'b0011: info_o.y = 3'd3;
            4'b1101, 4'b0010: info_o.y = 3'd4;
            4'b1010: begin info_o.y = 3'd5; info_o.mid_bal = 1'b1; end
            4'b0110: begin info_o.y = 3'd6; info_o.mid_bal = 1'b1; end
            4'b1110, 4'b0001: begin info_o.y = 3'd7; info_o.pri7 = 1'b1; end
            4'b0111, 4'b1000: begin info_o.y = 3'd7; info_o.alt7 = 1'b1; end
            default:          info_o.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/lane_dec_chain.sv
`timescale 1ns/1ps
module lane_dec_chain
    import lane_decoder_pkg::*;
#(
    parameter disp_e START = DISP_NEG
) (
    input  logic hi_valid,
    input  logic hi_need_neg,
    input  logic hi_need_pos,
    input  logic hi_go_pos,
    input  logic hi_go_neg,
    input  logic lo_valid,
    input  logic lo_need_neg,
    input  logic lo_need_pos,
    input  logic pair_ok,
    output logic legal_o
);

    logic  hi_ok;
    logic  lo_ok;
    disp_e mid;

    always_comb begin
        hi_ok = hi_valid
              && !(hi_need_neg && (START == DISP_POS))
              && !(hi_need_pos && (START == DISP_NEG));
        if (hi_go_pos)      mid = DISP_POS;
        else if (hi_go_neg) mid = DISP_NEG;
        else                mid = START;
        lo_ok = lo_valid
              && !(lo_need_neg && (mid == DISP_POS))
              && !(lo_need_pos && (mid == DISP_NEG));
        legal_o = hi_ok && lo_ok && pair_ok;
    end

endmodule

// File: rtl/lane_decoder.sv
`timescale 1ns/1ps
module lane_decoder
    import lane_decoder_pkg::*;
#(
    parameter logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC,
    parameter disp_e             RESET_DISP = DISP_NEG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_vld,
    input  logic [SYM_W-1:0]  sym_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              ctl_out,
    output logic              aux_out,
    output logic              err_out
);

    localparam int N_DISP = 2;

    hi_info_t          hi;
    lo_info_t          lo;
    logic [N_DISP-1:0] legal_at;
    logic              pair_ok;
    logic              legal_cur;
    logic              legal_alt;
    logic              swing_up;
    logic              swing_dn;
    logic [BYTE_W-1:0] dec_byte;
    logic              dec_k;
    disp_e             disp_q;
    disp_e             disp_d;
    verdict_e          verdict;

    lane_dec_hi u_hi (.sub_i(sym_in[SYM_W-1:LO_W]), .info_o(hi));
    lane_dec_lo u_lo (.sub_i(sym_in[LO_W-1:0]),     .info_o(lo));

    // Pairing rules between the two sub-blocks; independent of disparity
    always_comb begin
        pair_ok = 1'b1;
        if (lo.alt7)
            pair_ok = (hi.run_hi && lo.need_neg) || (hi.run_lo && lo.need_pos)
                   || hi.kx7 || hi.is_k28;
        else if (lo.pri7)
            pair_ok = !(hi.run_hi && lo.need_neg) && !(hi.run_lo && lo.need_pos)
                   && !hi.is_k28;
    end

    generate
        for (genvar g = 0; g < N_DISP; g++) begin : g_chain
            lane_dec_chain #(.START(disp_e'(g))) u_chain (
                .hi_valid   (hi.valid),
                .hi_need_neg(hi.need_neg),
                .hi_need_pos(hi.need_pos),
                .hi_go_pos  (hi.go_pos),
                .hi_go_neg  (hi.go_neg),
                .lo_valid   (lo.valid),
                .lo_need_neg(lo.need_neg),
                .lo_need_pos(lo.need_pos),
                .pair_ok    (pair_ok),
                .legal_o    (legal_at[g])
            );
        end
    endgenerate

    assign legal_cur = (disp_q == DISP_POS) ? legal_at[1] : legal_at[0];
    assign legal_alt = (disp_q == DISP_POS) ? legal_at[0] : legal_at[1];

    assign dec_byte = {lo.y ^ {Y_W{hi.k28_pos & lo.mid_bal}}, hi.x};
    assign dec_k    = hi.is_k28 || (hi.kx7 && lo.alt7);

    assign swing_up = lo.go_pos || (!lo.go_neg && hi.go_pos);
    assign swing_dn = lo.go_neg || (!lo.go_pos && hi.go_neg);

    // Disparity tracker: transitions SWING_UP, SWING_DOWN, HOLD
    always_comb begin
        disp_d = disp_q;
        unique case (disp_q)
            DISP_NEG: if (sym_vld && swing_up) disp_d = DISP_POS;
            DISP_POS: if (sym_vld && swing_dn) disp_d = DISP_NEG;
            default:  disp_d = RESET_DISP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) disp_q <= RESET_DISP;
        else        disp_q <= disp_d;
    end

    // Ranked verdict: illegal code, wrong disparity, comma
    always_comb begin
        if (!legal_cur && !legal_alt)                    verdict = V_BADCODE;
        else if (!legal_cur)                             verdict = V_BADDISP;
        else if (dec_k && (dec_byte == COMMA_BYTE))      verdict = V_COMMA;
        else                                             verdict = V_DATA;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_out <= '0;
            ctl_out  <= 1'b0;
            aux_out  <= 1'b0;
            err_out  <= 1'b0;
        end else if (sym_vld) begin
            unique case (verdict)
                V_DATA: begin
                    byte_out <= dec_byte;
                    ctl_out  <= dec_k;
                    aux_out  <= 1'b0;
                    err_out  <= 1'b0;
                end
                V_COMMA: begin
                    byte_out <= dec_byte;
                    ctl_out  <= 1'b1;
                    aux_out  <= 1'b1;
                    err_out  <= 1'b0;
                end
                V_BADCODE: begin
                    byte_out <= '0;
                    ctl_out  <= 1'b0;
                    aux_out  <= 1'b1;
                    err_out  <= 1'b1;
                end
                V_BADDISP: begin
                    byte_out <= '0;
                    ctl_out  <= 1'b0;
                    aux_out  <= 1'b0;
                    err_out  <= 1'b1;
                end
                default: begin
                    byte_out <= '0;
                    ctl_out  <= 1'b0;
                    aux_out  <= 1'b0;
                    err_out  <= 1'b0;
                end
            endcase
        end
    end

    assert_badcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld && !legal_at[0] && !legal_at[1] |=> err_out && aux_out && !ctl_out);

    assert_baddisp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld && legal_alt && !legal_cur |=> err_out && !aux_out && !ctl_out);

    assert_comma_R3: assert property (@(posedge clk) disable iff (!rst_n)
        aux_out && !err_out |-> ctl_out && (byte_out == COMMA_BYTE));

    assert_quiet_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> !ctl_out && (byte_out == '0));

    assert_swing_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld && lo.go_pos |=> disp_q == DISP_POS);

    assert_swing_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld && lo.go_neg |=> disp_q == DISP_NEG);

    assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> $stable({byte_out, ctl_out, aux_out, err_out}));

    assert_hold_disp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> $stable(disp_q));

endmodule

// File: tb/lane_decoder_test.sv
`timescale 1ns/1ps
module lane_decoder_test;

    localparam real CLK_HALF = 2.5;
    localparam int  WD_CYC   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sym_vld;
    logic [9:0] sym_in;
    logic [7:0] byte_out;
    logic       ctl_out;
    logic       aux_out;
    logic       err_out;

    int  checks = 0;
    int  errors = 0;
    bit  model_rd = 1'b0;
    logic [10:0] last_exp = '0;

    always #(CLK_HALF) clk = ~clk;

    lane_decoder uut (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_in(sym_in),
        .byte_out(byte_out), .ctl_out(ctl_out), .aux_out(aux_out), .err_out(err_out)
    );

    function automatic logic [5:0] hi_neg(input logic [4:0] x);
        case (x)
            5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
            5'd10: return 6'b010101;  5'd11: return 6'b110100;
            5'd12: return 6'b001101;  5'd13: return 6'b101100;
            5'd14: return 6'b011100;  5'd15: return 6'b010111;
            5'd16: return 6'b011011;  5'd17: return 6'b100011;
            5'd18: return 6'b010011;  5'd19: return 6'b110010;
            5'd20: return 6'b001011;  5'd21: return 6'b101010;
            5'd22: return 6'b011010;  5'd23: return 6'b111010;
            5'd24: return 6'b110011;  5'd25: return 6'b100110;
            5'd26: return 6'b010110;  5'd27: return 6'b110110;
            5'd28: return 6'b001110;  5'd29: return 6'b101110;
            5'd30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] lo_neg(input logic [2:0] y);
        case (y)
            3'd0: return 4'b1011; 3'd1: return 4'b1001;
            3'd2: return 4'b0101; 3'd3: return 4'b1100;
            3'd4: return 4'b1101; 3'd5: return 4'b1010;
            3'd6: return 4'b0110; default: return 4'b1110;
        endcase
    endfunction

    function automatic logic [3:0] lo_k28(input logic [2:0] y);
        case (y)
            3'd0: return 4'b0100; 3'd1: return 4'b1001;
            3'd2: return 4'b0101; 3'd3: return 4'b0011;
            3'd4: return 4'b0010; 3'd5: return 4'b1010;
            3'd6: return 4'b0110; default: return 4'b1000;
        endcase
    endfunction

    function automatic logic [9:0] encode(input logic [7:0] b, input bit k, input bit rd);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] s;
        logic [3:0] f;
        bit         r1;
        x = b[4:0];
        y = b[7:5];
        if (k && x == 5'd28) begin
            return rd ? ~{6'b001111, lo_k28(y)} : {6'b001111, lo_k28(y)};
        end
        s = hi_neg(x);
        if (rd && ($countones(s) != 3 || s == 6'b111000)) s = ~s;
        r1 = rd;
        if ($countones(s) > 3)      r1 = 1'b1;
        else if ($countones(s) < 3) r1 = 1'b0;
        if (y == 3'd7 && (k || (!r1 && (x == 5'd17 || x == 5'd18 || x == 5'd20))
                            || (r1 && (x == 5'd11 || x == 5'd13 || x == 5'd14))))
            f = r1 ? 4'b1000 : 4'b0111;
        else begin
            f = lo_neg(y);
            if (r1 && ($countones(f) != 2 || f == 4'b1100)) f = ~f;
        end
        return {s, f};
    endfunction

    function automatic logic [7:0] ksym(input int j);
        if (j < 8)   return {3'(j), 5'd28};
        if (j == 8)  return {3'd7, 5'd23};
        if (j == 9)  return {3'd7, 5'd27};
        if (j == 10) return {3'd7, 5'd29};
        return {3'd7, 5'd30};
    endfunction

    function automatic bit find_sym(input logic [9:0] cw, input bit rd,
                                    output logic [7:0] b, output bit k);
        b = '0;
        k = 1'b0;
        for (int i = 0; i < 256; i++) begin
            if (encode(8'(i), 1'b0, rd) == cw) begin b = 8'(i); return 1'b1; end
        end
        for (int j = 0; j < 12; j++) begin
            if (encode(ksym(j), 1'b1, rd) == cw) begin b = ksym(j); k = 1'b1; return 1'b1; end
        end
        return 1'b0;
    endfunction

    function automatic bit next_rd(input logic [9:0] cw, input bit rd);
        if ($countones(cw[3:0]) > 2) return 1'b1;
        if ($countones(cw[3:0]) < 2) return 1'b0;
        if ($countones(cw[9:4]) > 3) return 1'b1;
        if ($countones(cw[9:4]) < 3) return 1'b0;
        return rd;
    endfunction

    task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic send(input logic [9:0] cw, input string tag_in);
        logic [7:0] b_cur, b_alt;
        bit         k_cur, k_alt, ok_cur, ok_alt;
        logic [10:0] exp;
        string      tag;
        ok_cur = find_sym(cw, model_rd, b_cur, k_cur);
        ok_alt = find_sym(cw, !model_rd, b_alt, k_alt);
        if (!ok_cur && !ok_alt) begin exp = {1'b1, 1'b1, 1'b0, 8'h00}; tag = "R4"; end
        else if (!ok_cur)       begin exp = {1'b1, 1'b0, 1'b0, 8'h00}; tag = "R5"; end
        else if (k_cur && b_cur == 8'hBC) begin exp = {1'b0, 1'b1, 1'b1, b_cur}; tag = "R3"; end
        else if (k_cur)         begin exp = {1'b0, 1'b0, 1'b1, b_cur}; tag = "R2"; end
        else                    begin exp = {1'b0, 1'b0, 1'b0, b_cur}; tag = "R1"; end
        if (tag_in != "") tag = tag_in;
        sym_in  = cw;
        sym_vld = 1'b1;
        @(negedge clk);
        check(tag, {err_out, aux_out, ctl_out, byte_out}, exp);
        last_exp = exp;
        model_rd = next_rd(cw, model_rd);
    endtask

    initial begin
        #(WD_CYC * 2 * CLK_HALF);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        sym_vld = 1'b0;
        sym_in  = 10'h3FF;
        repeat (3) @(negedge clk);
        check("R9", {err_out, aux_out, ctl_out, byte_out}, 11'h000);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset disparity is negative: negative-form comma decodes clean
        send(10'b0011111010, "R7");
        // Same comma form now at positive disparity: disparity fault outranks comma
        send(10'b0011111010, "R6");
        // Wrong-disparity six-bit part with an illegal four-bit part: illegal code
        send(10'b1001111111, "R6");

        // Hold: a word that would swing the disparity negative is ignored
        sym_vld = 1'b0;
        sym_in  = 10'h000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8", {err_out, aux_out, ctl_out, byte_out}, last_exp);
        end
        // Positive-form comma decodes clean only if disparity stayed positive
        send(10'b1100000101, "R8");

        // Every legal symbol at the running disparity
        for (int i = 0; i < 256; i++) send(encode(8'(i), 1'b0, model_rd), "");
        for (int j = 0; j < 12; j++)  send(encode(ksym(j), 1'b1, model_rd), "");

        // Every code word under both disparities, steered by D.0.1 (net flip)
        for (int cw = 0; cw < 1024; cw++) begin
            for (int t = 0; t < 2; t++) begin
                if (model_rd != bit'(t)) send(encode(8'h20, 1'b0, model_rd), "R7");
                send(10'(cw), "");
            end
        end

        sym_vld = 1'b0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule